// File: doc/BRIEF.md
# Floating-Point Status Register Unit

This block keeps the accrued floating-point exception flags and the dynamic rounding mode of a processor core. Software reaches them through three views chosen by a view code: the flags alone, the rounding mode alone, or one combined word that packs both. Every access is qualified by the floating-point state field (FS) of the machine status register. The block reads that field as an input and raises a one-cycle request that tells the field's owner to set it to the dirty code.

The floating-point datapath reports new exceptions through an OR-in port. Read data, the illegal-access flag and the dirty request are all registered, so they appear in the cycle after the access. A read returns the value held before any write made in the same cycle.

Top module: `fpst_unit`

## Requirements
- R1: An access with view code 0, 1 or 2 is illegal when `fs_state` is 2'b00 and `acc_debug` is low. An illegal access raises `acc_illegal` one cycle later with `acc_rdata` zero, and it changes neither field.
- R2: With `acc_debug` high, an access to view 0, 1 or 2 is legal whatever the value of `fs_state`.
- R3: A legal write raises `fs_mark_dirty` for exactly one cycle, in the cycle after the write. A write that is illegal does not raise it.
- R4: A read with no write and no OR-in leaves `fs_mark_dirty` low.
- R5: View 0 (flags) reads the 5 flag bits at [4:0] with all upper bits zero. A write to it keeps write-data bits [4:0] only.
- R6: View 1 (rounding mode) reads the 3-bit mode at [2:0] with all upper bits zero. A write to it keeps write-data bits [2:0] only.
- R7: View 2 (combined) reads the flags at [4:0] and the mode at [7:5], with bits above 7 zero. A write to it loads the flags from [4:0] and the mode from [7:5].
- R8: While `flag_set_valid` is high, `flag_set_bits` are ORed into the flags. This happens even when FS is off. `fs_mark_dirty` rises the next cycle only when `fs_state` is not 2'b00.
- R9: When a legal flag write and an OR-in land in the same cycle, the flags become the written value ORed with the OR-in bits.
- R10: Reset clears the flags, the mode and all outputs.
- R11: View code 3 is always illegal, including debug accesses.
- R12: Read data shows the value held before a write made in the same cycle. The new value is visible from the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_view | input | 2 | View code: 0 flags, 1 rounding mode, 2 combined, 3 none |
| acc_write | input | 1 | Access also writes |
| acc_wdata | input | XLEN (32) | Write data |
| acc_debug | input | 1 | Access comes from a debugger |
| fs_state | input | 2 | Current FS field; 2'b00 means off |
| flag_set_valid | input | 1 | Datapath reports exceptions this cycle |
| flag_set_bits | input | 5 | Exception bits to OR into the flags |
| acc_rdata | output | XLEN (32) | Registered read data |
| acc_illegal | output | 1 | Registered illegal-access pulse |
| fs_mark_dirty | output | 1 | Registered request to set FS to 2'b11 |

## Verification
The hardest situation to reach from the ports is the collision of a software write with a datapath OR-in, especially when FS is off or the access is illegal. Independent random streams rarely line these up in one cycle. The stimulus therefore draws the OR-in enable, the debug qualifier and an FS value biased toward off for every access. Directed cases then force a combined-view write together with an OR-in, and a debug write at FS off. Each field is read back on a later access so that its effect is seen at the ports.

// File: rtl/fpst_pkg.sv
package fpst_pkg;
  typedef enum logic [1:0] {
    VIEW_FLAGS = 2'd0,
    VIEW_RMODE = 2'd1,
    VIEW_BOTH  = 2'd2,
    VIEW_NONE  = 2'd3
  } view_e;
endpackage

// File: rtl/fpst_gate.sv
module fpst_gate #(
  parameter int FS_W = 2
) (
  input  logic            acc_valid,
  input  logic [1:0]      acc_view,
  input  logic            acc_write,
  input  logic            acc_debug,
  input  logic [FS_W-1:0] fs_state,
  input  logic            flag_set_valid,
  output logic            legal,
  output logic            illegal,
  output logic            wr_ok,
  output logic            dirty_req
);
  import fpst_pkg::*;

  logic fs_off;
  logic view_known;

  assign fs_off     = ~|fs_state;
  assign view_known = (view_e'(acc_view) != VIEW_NONE);

  always_comb begin
    legal     = acc_valid && view_known && (!fs_off || acc_debug);
    illegal   = acc_valid && !legal;
    wr_ok     = legal && acc_write;
    dirty_req = wr_ok || (flag_set_valid && !fs_off);
  end
endmodule

// File: rtl/fpst_store.sv
module fpst_store #(
  parameter int XLEN   = 32,
  parameter int FLAG_W = 5,
  parameter int RM_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic [1:0]        acc_view,
  input  logic [XLEN-1:0]   acc_wdata,
  input  logic              flag_set_valid,
  input  logic [FLAG_W-1:0] flag_set_bits,
  output logic [FLAG_W-1:0] flags_q,
  output logic [RM_W-1:0]   rmode_q
);
  import fpst_pkg::*;

  localparam int RM_LSB = FLAG_W;

  logic [FLAG_W-1:0] flags_d;
  logic [RM_W-1:0]   rmode_d;
  logic [FLAG_W-1:0] or_in;

  genvar gi;
  generate
    for (gi = 0; gi < FLAG_W; gi++) begin : g_orin
      assign or_in[gi] = flag_set_valid & flag_set_bits[gi];
    end
  endgenerate

  always_comb begin
    flags_d = flags_q;
    rmode_d = rmode_q;
    if (wr_ok) begin
      unique case (view_e'(acc_view))
        VIEW_FLAGS: flags_d = acc_wdata[FLAG_W-1:0];
        VIEW_RMODE: rmode_d = acc_wdata[RM_W-1:0];
        VIEW_BOTH: begin
          flags_d = acc_wdata[FLAG_W-1:0];
          rmode_d = acc_wdata[RM_LSB +: RM_W];
        end
        default: ;
      endcase
    end
    flags_d = flags_d | or_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      rmode_q <= '0;
    end else begin
      flags_q <= flags_d;
      rmode_q <= rmode_d;
    end
  end
endmodule

// File: rtl/fpst_resp.sv
module fpst_resp #(
  parameter int XLEN   = 32,
  parameter int FLAG_W = 5,
  parameter int RM_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              legal,
  input  logic              illegal,
  input  logic              dirty_req,
  input  logic [1:0]        acc_view,
  input  logic [FLAG_W-1:0] flags_q,
  input  logic [RM_W-1:0]   rmode_q,
  output logic [XLEN-1:0]   acc_rdata,
  output logic              acc_illegal,
  output logic              fs_mark_dirty
);
  import fpst_pkg::*;

  localparam int RM_LSB = FLAG_W;

  logic [XLEN-1:0] view_word;

  always_comb begin
    view_word = '0;
    unique case (view_e'(acc_view))
      VIEW_FLAGS: view_word[FLAG_W-1:0] = flags_q;
      VIEW_RMODE: view_word[RM_W-1:0]   = rmode_q;
      VIEW_BOTH: begin
        view_word[FLAG_W-1:0]      = flags_q;
        view_word[RM_LSB +: RM_W]  = rmode_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_rdata     <= '0;
      acc_illegal   <= 1'b0;
      fs_mark_dirty <= 1'b0;
    end else begin
      acc_rdata     <= legal ? view_word : '0;
      acc_illegal   <= illegal;
      fs_mark_dirty <= dirty_req;
    end
  end
endmodule

// File: rtl/fpst_unit.sv
module fpst_unit #(
  parameter int XLEN   = 32,
  parameter int FLAG_W = 5,
  parameter int RM_W   = 3,
  parameter int FS_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [1:0]        acc_view,
  input  logic              acc_write,
  input  logic [XLEN-1:0]   acc_wdata,
  input  logic              acc_debug,
  input  logic [FS_W-1:0]   fs_state,
  input  logic              flag_set_valid,
  input  logic [FLAG_W-1:0] flag_set_bits,
  output logic [XLEN-1:0]   acc_rdata,
  output logic              acc_illegal,
  output logic              fs_mark_dirty
);
  logic legal, illegal, wr_ok, dirty_req;
  logic [FLAG_W-1:0] flags_q;
  logic [RM_W-1:0]   rmode_q;
  logic              unused_hi;

  assign unused_hi = ^acc_wdata[XLEN-1:FLAG_W+RM_W];

  fpst_gate #(.FS_W(FS_W)) u_gate (
    .acc_valid(acc_valid), .acc_view(acc_view), .acc_write(acc_write),
    .acc_debug(acc_debug), .fs_state(fs_state),
    .flag_set_valid(flag_set_valid), .legal(legal), .illegal(illegal),
    .wr_ok(wr_ok), .dirty_req(dirty_req)
  );

  fpst_store #(.XLEN(XLEN), .FLAG_W(FLAG_W), .RM_W(RM_W)) u_store (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .acc_view(acc_view),
    .acc_wdata(acc_wdata), .flag_set_valid(flag_set_valid),
    .flag_set_bits(flag_set_bits), .flags_q(flags_q), .rmode_q(rmode_q)
  );

  fpst_resp #(.XLEN(XLEN), .FLAG_W(FLAG_W), .RM_W(RM_W)) u_resp (
    .clk(clk), .rst(rst), .legal(legal), .illegal(illegal),
    .dirty_req(dirty_req), .acc_view(acc_view), .flags_q(flags_q),
    .rmode_q(rmode_q), .acc_rdata(acc_rdata), .acc_illegal(acc_illegal),
    .fs_mark_dirty(fs_mark_dirty)
  );
endmodule

// File: rtl/fpst_unit_chk.sv
module fpst_unit_chk #(
  parameter int XLEN   = 32,
  parameter int FLAG_W = 5,
  parameter int RM_W   = 3,
  parameter int FS_W   = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            acc_valid,
  input logic [1:0]      acc_view,
  input logic            acc_write,
  input logic            acc_debug,
  input logic [FS_W-1:0] fs_state,
  input logic            flag_set_valid,
  input logic [XLEN-1:0] acc_rdata,
  input logic            acc_illegal,
  input logic            fs_mark_dirty
);
  logic chk_legal;
  assign chk_legal = acc_valid && (acc_view != 2'd3) &&
                     ((fs_state != '0) || acc_debug);

  AST_ILLEGAL_FS_OFF: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_view != 2'd3 && fs_state == '0 && !acc_debug) |=> acc_illegal); // R1
  AST_ILLEGAL_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    acc_illegal |-> (acc_rdata == '0)); // R1
  AST_DEBUG_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_debug && acc_view != 2'd3) |=> !acc_illegal); // R2
  AST_WRITE_DIRTY: assert property (@(posedge clk) disable iff (rst)
    (chk_legal && acc_write) |=> fs_mark_dirty); // R3
  AST_READ_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (!(acc_valid && acc_write) && !flag_set_valid) |=> !fs_mark_dirty); // R4
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (acc_rdata[XLEN-1:FLAG_W+RM_W] == '0)); // R7
  AST_VIEW_NONE: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_view == 2'd3) |=> acc_illegal); // R11
endmodule

bind fpst_unit fpst_unit_chk #(.XLEN(XLEN), .FLAG_W(FLAG_W), .RM_W(RM_W), .FS_W(FS_W)) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_view(acc_view),
  .acc_write(acc_write), .acc_debug(acc_debug), .fs_state(fs_state),
  .flag_set_valid(flag_set_valid), .acc_rdata(acc_rdata),
  .acc_illegal(acc_illegal), .fs_mark_dirty(fs_mark_dirty)
);

// File: tb/fpst_unit_bench.sv
module fpst_unit_bench;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 1'b0;
  logic [1:0] acc_view = 2'd0;
  logic acc_write = 1'b0;
  logic [XLEN-1:0] acc_wdata = '0;
  logic acc_debug = 1'b0;
  logic [1:0] fs_state = 2'd0;
  logic flag_set_valid = 1'b0;
  logic [4:0] flag_set_bits = '0;
  logic [XLEN-1:0] acc_rdata;
  logic acc_illegal;
  logic fs_mark_dirty;

  int tests = 0;
  int fails = 0;
  logic [4:0] m_flags = '0;
  logic [2:0] m_rm = '0;

  always #5 clk = ~clk;

  fpst_unit u_fpst_unit (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_view(acc_view),
    .acc_write(acc_write), .acc_wdata(acc_wdata), .acc_debug(acc_debug),
    .fs_state(fs_state), .flag_set_valid(flag_set_valid),
    .flag_set_bits(flag_set_bits), .acc_rdata(acc_rdata),
    .acc_illegal(acc_illegal), .fs_mark_dirty(fs_mark_dirty)
  );

  function automatic logic [XLEN-1:0] view_val(input logic [1:0] v);
    logic [XLEN-1:0] w = '0;
    case (v)
      2'd0: w[4:0] = m_flags;
      2'd1: w[2:0] = m_rm;
      2'd2: begin w[4:0] = m_flags; w[7:5] = m_rm; end
      default: w = '0;
    endcase
    return w;
  endfunction

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input string req, input logic v, input logic [1:0] view, input logic we,
                    input logic [XLEN-1:0] wd, input logic dbg, input logic [1:0] fs,
                    input logic sv, input logic [4:0] sb);
    logic legal, e_dirty;
    logic [XLEN-1:0] e_rd;
    @(negedge clk);
    acc_valid = v; acc_view = view; acc_write = we; acc_wdata = wd;
    acc_debug = dbg; fs_state = fs; flag_set_valid = sv; flag_set_bits = sb;
    legal   = v && view != 2'd3 && (fs != 2'd0 || dbg);
    e_rd    = legal ? view_val(view) : '0;
    e_dirty = (legal && we) || (sv && fs != 2'd0);
    @(posedge clk); #1;
    check({req, " rdata"}, acc_rdata, e_rd);
    check({req, " illegal"}, {31'd0, acc_illegal}, {31'd0, v && !legal});
    check({req, " dirty"}, {31'd0, fs_mark_dirty}, {31'd0, e_dirty});
    if (legal && we) begin
      if (view == 2'd0 || view == 2'd2) m_flags = wd[4:0];
      if (view == 2'd1) m_rm = wd[2:0];
      if (view == 2'd2) m_rm = wd[7:5];
    end
    if (sv) m_flags = m_flags | sb;
    acc_valid = 1'b0; acc_write = 1'b0; flag_set_valid = 1'b0;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset rdata", acc_rdata, '0);
    check("R10 reset dirty", {31'd0, fs_mark_dirty}, '0);
    @(negedge clk); rst = 1'b0;
    op("R10 read after reset", 1, 2'd2, 0, '0, 1, 2'd0, 0, '0);
    op("R1 write fs off", 1, 2'd2, 1, 32'hFF, 0, 2'd0, 0, '0);
    op("R1 readback", 1, 2'd2, 0, '0, 1, 2'd1, 0, '0);
    op("R2 debug write fs off", 1, 2'd2, 1, 32'hFFFF_FFFF, 1, 2'd0, 0, '0);
    op("R7 R12 readback all ones", 1, 2'd2, 0, '0, 0, 2'd1, 0, '0);
    op("R5 flags write", 1, 2'd0, 1, 32'hFFFF_FFEA, 0, 2'd3, 0, '0);
    op("R5 flags read", 1, 2'd0, 0, '0, 0, 2'd3, 0, '0);
    op("R6 rmode write", 1, 2'd1, 1, 32'hFFFF_FFF9, 0, 2'd2, 0, '0);
    op("R6 rmode read", 1, 2'd1, 0, '0, 0, 2'd2, 0, '0);
    op("R11 view none debug", 1, 2'd3, 1, 32'h0, 1, 2'd3, 0, '0);
    op("R8 orin fs off", 0, 2'd0, 0, '0, 0, 2'd0, 1, 5'h10);
    op("R8 orin fs on", 0, 2'd0, 0, '0, 0, 2'd1, 1, 5'h01);
    op("R8 readback", 1, 2'd0, 0, '0, 0, 2'd1, 0, '0);
    op("R9 write plus orin", 1, 2'd2, 1, 32'h0000_0044, 0, 2'd1, 1, 5'h03);
    op("R9 readback", 1, 2'd2, 0, '0, 0, 2'd1, 0, '0);
    op("R4 plain read", 1, 2'd1, 0, '0, 0, 2'd3, 0, '0);
    for (int i = 0; i < 400; i++) begin
      op("R3 random", ($urandom % 4) != 0, 2'($urandom), 1'($urandom),
         $urandom, ($urandom % 4) == 0, (($urandom % 3) == 0) ? 2'd0 : 2'($urandom),
         ($urandom % 3) == 0, 5'($urandom));
    end
    op("R7 final read", 1, 2'd2, 0, '0, 1, 2'd0, 0, '0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule